// File: doc/BRIEF.md
# Long-Press Dual-Button Reset Generator

This block turns two push-button lines into a system reset that only fires on a deliberate long press. The reset fires only when both buttons are held down together, without a break, for a programmable number of clock cycles. A shorter press never resets the system. When the buttons are let go early, the block instead emits a one-cycle strobe that an interrupt controller can use. A supply-undervoltage flag also drives the reset. After that flag clears, the reset is held for one more full pulse length. The same stretch follows the release of the block's own reset, so the system starts with a clean reset pulse.

All three asynchronous inputs pass through a two-flop synchronizer before any timing logic sees them. Software supplies the hold time and the pulse length as tick counts. One shared counter times the hold, the pulse and the recovery stretch in turn.

Top module: `long_press_reset`

## Requirements
- R1: The hold timer advances only on cycles where both synchronized buttons read low. One button held for any length of time never causes a reset. Releasing either button during a hold clears the count and returns the block to idle.
- R2: If both buttons are seen low on fewer than `setup_ticks` consecutive sampling edges, `sys_rst_n` stays high.
- R3: When both buttons are seen low on `setup_ticks` consecutive sampling edges, `sys_rst_n` goes low after that edge. It stays low for exactly `pulse_ticks` clock cycles.
- R4: `setup_ticks` and `pulse_ticks` are counts of clock cycles, and a value of 0 behaves as 1. `sys_rst_n` is active low: 0 means the system is held in reset.
- R5: On every cycle that follows a sampling edge at which the synchronized `uv_flag` is 1, `sys_rst_n` is low, whatever the buttons do.
- R6: After the synchronized `uv_flag` returns to 0, `sys_rst_n` stays low for a further `pulse_ticks` cycles. A flag held high for N edges therefore gives N + `pulse_ticks` low cycles.
- R7: `sys_rst_n` is low while `rst_n` is low. It rises at the `pulse_ticks`-th rising edge at which `rst_n` is sampled high.
- R8: A both-button press released before the setup count completes raises `short_press` for exactly one cycle. `short_press` never rises while `sys_rst_n` is low, and a press that produces a reset produces no strobe.
- R9: A single long press, however long it is held, yields exactly one reset pulse. A new pulse needs both buttons to be seen released first.
- R10: Each of `btn_a_n`, `btn_b_n` and `uv_flag` is taken through two flip-flops. A change first captured at rising edge k is acted on at edge k+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; also the power-on indication |
| btn_a_n | input | 1 | First push-button, active low, asynchronous |
| btn_b_n | input | 1 | Second push-button, active low, asynchronous |
| uv_flag | input | 1 | Supply undervoltage, active high, asynchronous |
| setup_ticks | input | CW | Hold time in clock cycles (0 acts as 1) |
| pulse_ticks | input | CW | Reset pulse and recovery length in clock cycles (0 acts as 1) |
| sys_rst_n | output | 1 | System reset, active low |
| short_press | output | 1 | One-cycle strobe for a press released before the setup time |

## Verification
The bound checker checks several relations on every cycle:
- the undervoltage override;
- the stretch that starts when the flag falls;
- the single-cycle shape of the strobe, and that it never appears while reset is asserted;
- that an idle block with only one button down stays out of reset;
- the bound on the pulse counter;
- that the block stays in the wait-for-release state while any button is held.

Several properties need whole scenarios driven against the bench's reference model:
- the exact count of low cycles for a pulse, for a power-on stretch and for an undervoltage episode;
- the boundary between `setup_ticks`-1 and `setup_ticks` held cycles;
- the zero-count case;
- the two-edge synchronizer latency;
- re-arming after a long press.

// File: rtl/lpr_pkg.sv
// Shared types for the long-press reset generator.
// Assumes: included first in compile order.
package lpr_pkg;

    typedef enum logic [2:0] {
        ST_RECOVER = 3'd0,   // stretch after power-on or undervoltage
        ST_IDLE    = 3'd1,
        ST_HOLD    = 3'd2,   // both buttons down, counting
        ST_PULSE   = 3'd3,   // button-initiated reset pulse
        ST_WAITREL = 3'd4,   // pulse done, waiting for full release
        ST_UVHOLD  = 3'd5    // undervoltage present
    } lpr_state_e;

endpackage

// File: rtl/lpr_sync.sv
// Multi-stage flip-flop synchronizer for a bundle of asynchronous inputs.
// Assumes: each bit is independent; reset value is chosen per bit by RST_VAL.
module lpr_sync #(
    parameter int          WIDTH   = 3,
    parameter int          STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [STAGES-1:0][WIDTH-1:0] stage_q;

    // Shift the raw inputs through the stage chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= RST_VAL;
        end else begin
            stage_q[0] <= d;
            for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
        end
    end

    assign q = stage_q[STAGES-1];

endmodule

// File: rtl/lpr_tick_counter.sv
// Saturating up-counter shared by all timed phases of the controller.
// Assumes: clr has priority over inc; the count holds at all-ones.
module lpr_tick_counter #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          inc,
    output logic [CW-1:0] count
);

    logic [CW-1:0] count_q;

    // Clear, advance or hold the tick count.
    always_ff @(posedge clk) begin
        if (!rst_n)                        count_q <= '0;
        else if (clr)                      count_q <= '0;
        else if (inc && (count_q != '1))   count_q <= count_q + 1'b1;
    end

    assign count = count_q;

endmodule

// File: rtl/lpr_ctrl.sv
// Sequencing FSM: hold timing, pulse, release wait, undervoltage override
// and post-reset stretch. Drives the counter controls and both outputs.
// Assumes: inputs already synchronized; tick limits stable during a phase.
module lpr_ctrl
    import lpr_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          both_s,
    input  logic          any_s,
    input  logic          uv_s,
    input  logic [CW-1:0] setup_ticks,
    input  logic [CW-1:0] pulse_ticks,
    input  logic [CW-1:0] cnt,
    output logic          cnt_clr,
    output logic          cnt_inc,
    output lpr_state_e    state,
    output logic          sys_rst_n,
    output logic          short_press
);

    localparam logic [CW:0] ONE = {{CW{1'b0}}, 1'b1};
    localparam logic [CW:0] TWO = {{(CW-1){1'b0}}, 2'b10};

    lpr_state_e  st_q, st_nxt;
    logic        sp_q, sp_nxt;
    logic [CW:0] setup_eff, pulse_eff, cnt_ext;
    logic        hold_done, pulse_done;

    // Effective limits: a zero count behaves as one.
    always_comb begin
        setup_eff  = (setup_ticks == '0) ? ONE : {1'b0, setup_ticks};
        pulse_eff  = (pulse_ticks == '0) ? ONE : {1'b0, pulse_ticks};
        cnt_ext    = {1'b0, cnt};
        hold_done  = (cnt_ext + TWO) >= setup_eff;
        pulse_done = (cnt_ext + ONE) >= pulse_eff;
    end

    // Next-state and counter-control decode.
    always_comb begin
        st_nxt  = st_q;
        cnt_clr = 1'b0;
        cnt_inc = 1'b0;
        sp_nxt  = 1'b0;
        if (uv_s) begin
            st_nxt  = ST_UVHOLD;
            cnt_clr = 1'b1;
        end else begin
            unique case (st_q)
                ST_RECOVER: begin
                    if (pulse_done) begin
                        st_nxt  = ST_IDLE;
                        cnt_clr = 1'b1;
                    end else begin
                        cnt_inc = 1'b1;
                    end
                end
                ST_IDLE: begin
                    cnt_clr = 1'b1;
                    if (both_s) st_nxt = (setup_eff == ONE) ? ST_PULSE : ST_HOLD;
                end
                ST_HOLD: begin
                    if (!both_s) begin
                        st_nxt  = ST_IDLE;
                        cnt_clr = 1'b1;
                        sp_nxt  = 1'b1;
                    end else if (hold_done) begin
                        st_nxt  = ST_PULSE;
                        cnt_clr = 1'b1;
                    end else begin
                        cnt_inc = 1'b1;
                    end
                end
                ST_PULSE: begin
                    if (pulse_done) begin
                        st_nxt  = ST_WAITREL;
                        cnt_clr = 1'b1;
                    end else begin
                        cnt_inc = 1'b1;
                    end
                end
                ST_WAITREL: begin
                    cnt_clr = 1'b1;
                    if (!any_s) st_nxt = ST_IDLE;
                end
                ST_UVHOLD: begin
                    st_nxt  = ST_RECOVER;
                    cnt_clr = 1'b1;
                end
                default: begin
                    st_nxt  = ST_RECOVER;
                    cnt_clr = 1'b1;
                end
            endcase
        end
    end

    // State and strobe registers; reset enters the recovery stretch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= ST_RECOVER;
            sp_q <= 1'b0;
        end else begin
            st_q <= st_nxt;
            sp_q <= sp_nxt;
        end
    end

    assign state       = st_q;
    assign short_press = sp_q;
    assign sys_rst_n   = !((st_q == ST_RECOVER) || (st_q == ST_PULSE) || (st_q == ST_UVHOLD));

endmodule

// File: rtl/long_press_reset.sv
// Top level: synchronizer, shared tick counter and sequencing FSM.
// Assumes: rst_n is synchronous to clk and doubles as the power-on signal.
module long_press_reset
    import lpr_pkg::*;
#(
    parameter int CW          = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          btn_a_n,
    input  logic          btn_b_n,
    input  logic          uv_flag,
    input  logic [CW-1:0] setup_ticks,
    input  logic [CW-1:0] pulse_ticks,
    output logic          sys_rst_n,
    output logic          short_press
);

    localparam int         NSYNC    = 3;
    localparam logic [NSYNC-1:0] SYNC_RST = 3'b011;   // buttons released, no undervoltage

    logic [NSYNC-1:0] sync_q;
    logic             both_s, any_s, uv_s;
    logic             cnt_clr, cnt_inc;
    logic [CW-1:0]    cnt;
    lpr_state_e       state;

    lpr_sync #(.WIDTH(NSYNC), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({uv_flag, btn_b_n, btn_a_n}),
        .q     (sync_q)
    );

    // Combine the synchronized button lines.
    always_comb begin
        both_s = !sync_q[0] && !sync_q[1];
        any_s  = !sync_q[0] || !sync_q[1];
        uv_s   = sync_q[2];
    end

    lpr_tick_counter #(.CW(CW)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .inc   (cnt_inc),
        .count (cnt)
    );

    lpr_ctrl #(.CW(CW)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .both_s      (both_s),
        .any_s       (any_s),
        .uv_s        (uv_s),
        .setup_ticks (setup_ticks),
        .pulse_ticks (pulse_ticks),
        .cnt         (cnt),
        .cnt_clr     (cnt_clr),
        .cnt_inc     (cnt_inc),
        .state       (state),
        .sys_rst_n   (sys_rst_n),
        .short_press (short_press)
    );

endmodule

// File: rtl/lpr_checker.sv
// Property checker for long_press_reset, attached by bind below.
// Assumes: tick limits are only changed while the block is idle.
module lpr_checker
    import lpr_pkg::*;
#(
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          uv_s,
    input logic          both_s,
    input logic          any_s,
    input lpr_state_e    state,
    input logic [CW-1:0] cnt,
    input logic [CW-1:0] pulse_ticks,
    input logic          sys_rst_n,
    input logic          short_press
);

    AST_UV_FORCES_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        uv_s |=> !sys_rst_n);  // R5

    AST_UV_STRETCH_START: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(uv_s) |=> !sys_rst_n);  // R6

    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        short_press |=> !short_press);  // R8

    AST_STROBE_OUT_OF_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        short_press |-> sys_rst_n);  // R8

    AST_ONE_BUTTON_NO_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !uv_s && !both_s) |=> sys_rst_n);  // R1

    AST_PULSE_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PULSE) |-> ((cnt < pulse_ticks) || (cnt == '0)));  // R3

    AST_WAIT_NO_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAITREL) |-> sys_rst_n);  // R9

    AST_WAIT_UNTIL_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAITREL && !uv_s && any_s) |=> (state == ST_WAITREL));  // R9

endmodule

bind long_press_reset lpr_checker #(.CW(CW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .uv_s        (uv_s),
    .both_s      (both_s),
    .any_s       (any_s),
    .state       (state),
    .cnt         (cnt),
    .pulse_ticks (pulse_ticks),
    .sys_rst_n   (sys_rst_n),
    .short_press (short_press)
);

// File: tb/sim_long_press_reset.sv
`timescale 1ns/1ps
module sim_long_press_reset;

    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          btn_a_n = 1'b1;
    logic          btn_b_n = 1'b1;
    logic          uv_flag = 1'b0;
    logic [CW-1:0] setup_ticks = 16'd10;
    logic [CW-1:0] pulse_ticks = 16'd6;
    logic          sys_rst_n;
    logic          short_press;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    long_press_reset #(.CW(CW)) u0 (
        .clk, .rst_n, .btn_a_n, .btn_b_n, .uv_flag,
        .setup_ticks, .pulse_ticks, .sys_rst_n, .short_press
    );

    // ---------------- behavioural reference model ----------------
    localparam int M_REC = 0, M_IDLE = 1, M_HOLD = 2, M_PULSE = 3, M_WAIT = 4, M_UV = 5;
    logic [2:0] m_q[$];
    logic [2:0] m_v;
    int  m_mode = M_REC;
    int  m_n = 0;
    int  m_held = 0;
    int  m_se, m_pe;
    bit  m_sp = 1'b0;
    bit  started = 1'b0;
    bit  m_both, m_any;

    always @(posedge clk) begin
        started = 1'b1;
        m_sp = 1'b0;
        if (!rst_n) begin
            m_q.delete();
            m_q.push_back(3'b011);
            m_q.push_back(3'b011);
            m_mode = M_REC;
            m_n = 0;
        end else begin
            m_v = m_q.pop_front();
            m_q.push_back({uv_flag, btn_b_n, btn_a_n});
            m_both = !m_v[0] && !m_v[1];
            m_any  = !m_v[0] || !m_v[1];
            m_se = (setup_ticks == 0) ? 1 : int'(setup_ticks);
            m_pe = (pulse_ticks == 0) ? 1 : int'(pulse_ticks);
            if (m_v[2]) begin
                m_mode = M_UV;
            end else begin
                case (m_mode)
                    M_REC: begin
                        m_n++;
                        if (m_n >= m_pe) m_mode = M_IDLE;
                    end
                    M_IDLE: if (m_both) begin
                        m_held = 1;
                        if (m_held >= m_se) begin m_mode = M_PULSE; m_n = 0; end
                        else m_mode = M_HOLD;
                    end
                    M_HOLD: if (!m_both) begin
                        m_mode = M_IDLE;
                        m_sp = 1'b1;
                    end else begin
                        m_held++;
                        if (m_held >= m_se) begin m_mode = M_PULSE; m_n = 0; end
                    end
                    M_PULSE: begin
                        m_n++;
                        if (m_n >= m_pe) m_mode = M_WAIT;
                    end
                    M_WAIT: if (!m_any) m_mode = M_IDLE;
                    default: begin m_mode = M_REC; m_n = 0; end
                endcase
            end
            if (m_mode == M_UV) m_n = 0;
            else if (m_mode == M_REC && m_v[2] == 1'b0 && m_n == 0) m_n = 0;
        end
    end

    function automatic string mode_tag(int m);
        case (m)
            M_REC:   return "R7";
            M_PULSE: return "R3";
            M_UV:    return "R5";
            M_WAIT:  return "R9";
            M_HOLD:  return "R2";
            default: return "R1";
        endcase
    endfunction

    // Per-cycle comparison against the model, away from the active edge.
    always @(negedge clk) begin
        if (started && !done) begin
            bit exp_rst;
            exp_rst = !(m_mode == M_REC || m_mode == M_PULSE || m_mode == M_UV);
            checks++;
            if (sys_rst_n !== exp_rst) begin
                failures++;
                $display("FAIL %s sys_rst_n model compare at %0t: actual=%b expected=%b",
                         mode_tag(m_mode), $time, sys_rst_n, exp_rst);
            end
            checks++;
            if (short_press !== m_sp) begin
                failures++;
                $display("FAIL R8 short_press model compare at %0t: actual=%b expected=%b",
                         $time, short_press, m_sp);
            end
        end
    end

    // ---------------- scenario helpers ----------------
    int low_cnt = 0;
    int sp_cnt = 0;

    task automatic check(input string tag, input int actual, input int expected, input string what);
        checks++;
        if (actual != expected) begin
            failures++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, actual, expected);
        end
    endtask

    task automatic run(input logic a, input logic b, input logic u, input int n);
        for (int i = 0; i < n; i++) begin
            btn_a_n = a;
            btn_b_n = b;
            uv_flag = u;
            @(negedge clk);
            if (!sys_rst_n) low_cnt++;
            if (short_press) sp_cnt++;
        end
    endtask

    task automatic clear_counts();
        low_cnt = 0;
        sp_cnt = 0;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL R3 watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        // Power-on (R7)
        repeat (4) @(negedge clk);
        check("R7", int'(sys_rst_n), 0, "reset held during rst_n");
        check("R8", int'(short_press), 0, "no strobe during rst_n");
        rst_n = 1'b1;
        for (int i = 1; i < 6; i++) begin
            @(negedge clk);
            check("R7", int'(sys_rst_n), 0, "stretch after power-on");
        end
        @(negedge clk);
        check("R7", int'(sys_rst_n), 1, "release at pulse_ticks-th edge");
        run(1, 1, 0, 5);

        // One button alone (R1)
        clear_counts();
        run(0, 1, 0, 40); run(1, 1, 0, 5);
        run(1, 0, 0, 40); run(1, 1, 0, 5);
        check("R1", low_cnt, 0, "single button never resets");
        check("R1", sp_cnt, 0, "single button gives no strobe");

        // Interrupted holds restart the count (R1, R8)
        clear_counts();
        for (int k = 0; k < 6; k++) begin
            run(0, 0, 0, 7);
            run(0, 1, 0, 3);
        end
        run(1, 1, 0, 10);
        check("R1", low_cnt, 0, "broken holds do not accumulate");
        check("R8", sp_cnt, 6, "one strobe per broken hold");

        // setup_ticks-1 cycles (R2)
        clear_counts();
        run(0, 0, 0, 9); run(1, 1, 0, 10);
        check("R2", low_cnt, 0, "short press ignored");
        check("R8", sp_cnt, 1, "short press strobe");

        // exactly setup_ticks cycles (R3)
        clear_counts();
        run(0, 0, 0, 10); run(1, 1, 0, 20);
        check("R3", low_cnt, 6, "pulse length at setup boundary");
        check("R8", sp_cnt, 0, "no strobe on reset press");

        // long press: one pulse, then re-arm (R9)
        clear_counts();
        run(0, 0, 0, 60); run(1, 1, 0, 10);
        check("R9", low_cnt, 6, "one pulse per long press");
        clear_counts();
        run(0, 0, 0, 60); run(1, 1, 0, 10);
        check("R9", low_cnt, 6, "re-armed after release");

        // synchronizer latency with setup of one (R10)
        setup_ticks = 16'd1;
        btn_a_n = 1'b0; btn_b_n = 1'b0;
        @(negedge clk); check("R10", int'(sys_rst_n), 1, "no response at capture edge");
        @(negedge clk); check("R10", int'(sys_rst_n), 1, "no response at second edge");
        @(negedge clk); check("R10", int'(sys_rst_n), 0, "response at third edge");
        run(1, 1, 0, 15);

        // zero counts act as one (R4)
        setup_ticks = 16'd0; pulse_ticks = 16'd0;
        clear_counts();
        run(0, 0, 0, 3); run(1, 1, 0, 10);
        check("R4", low_cnt, 1, "zero limits behave as one");

        // longer setup, short pulse (R4)
        setup_ticks = 16'd25; pulse_ticks = 16'd3;
        clear_counts();
        run(0, 0, 0, 24); run(1, 1, 0, 10);
        check("R4", low_cnt, 0, "24 of 25 ignored");
        check("R8", sp_cnt, 1, "strobe at 24 of 25");
        clear_counts();
        run(0, 0, 0, 25); run(1, 1, 0, 10);
        check("R4", low_cnt, 3, "25 of 25 gives 3-cycle pulse");

        // undervoltage with stretch (R5, R6)
        pulse_ticks = 16'd6;
        clear_counts();
        run(1, 1, 1, 20);
        check("R5", int'(sys_rst_n), 0, "reset during undervoltage");
        run(0, 0, 1, 10);
        check("R5", int'(sys_rst_n), 0, "buttons do not lift undervoltage reset");
        run(1, 1, 0, 40);
        check("R6", low_cnt, 36, "undervoltage plus stretch length");

        run(1, 1, 0, 5);
        finish_run();
    end

endmodule